// File: doc/BRIEF.md
# Two-Level Cascaded Priority Interrupt Controller

This block gathers sixteen interrupt request lines into one processor interrupt. It holds two eight-input priority units: a master that takes lines 0 to 7 and a slave that takes lines 8 to 15. The slave's interrupt output enters the master on master input 2. That input is reserved for the cascade, so the external line 2 is not used. The resulting order of service, from highest to lowest, is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.

Each unit keeps three registers. The request register latches rising edges of the lines. The mask register excludes lines from priority resolution. The in-service register records requests that have been acknowledged but not yet ended. The processor samples `intOut` and pulses `ackStrobe` to take an 8-bit vector. It uses a one-cycle command port to change a mask, end a service (non-specific end of interrupt), reprogram a vector base, or select the nesting mode.

In normal nesting, while the master has its cascade input in service, the slave cannot interrupt again. In special nesting, a strictly higher-priority slave request still passes through. A chained end-of-interrupt command clears the master's bit only when the slave has nothing else pending or in service.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `intOut` is 0 and `vectorValid` is 0. All mask bits are set, and the request and in-service registers are clear. The vector bases are 0x08 for the master and 0x70 for the slave, and normal nesting is selected.
- R2: A rising edge on a line latches a request. A masked line never raises `intOut`, but its request stays latched and becomes visible once the line is unmasked.
- R3: On acknowledge, the highest-priority eligible request wins. Order is 0, 1, 8–15, then 3–7, with a lower index meaning higher priority within each unit. The vector is {5-bit base, 3-bit input index}. For a cascaded request, the slave's base and index are used.
- R4: While an in-service bit is set in a unit, that unit raises no request of the same or lower priority. A strictly higher-priority request still interrupts.
- R5: Command opcode 1 (end of interrupt) clears only the highest-priority set in-service bit of the addressed unit. `cmdTarget` 0 addresses the master and 1 addresses the slave.
- R6: In normal nesting, while master in-service bit 2 is set, no slave request reaches `intOut`, even a higher-priority one.
- R7: Command opcode 3 selects the nesting mode: `cmdData[0]` = 1 for special, 0 for normal. In special nesting, a slave request of strictly higher priority than the slave's highest in-service bit raises `intOut` while master bit 2 is in service. Equal and lower slave requests do not.
- R8: End of interrupt with `cmdTarget` = 1 and `cmdData[0]` = 1 also clears the master's highest in-service bit, but only if the slave has no other in-service bit and no unmasked pending request.
- R9: Command opcode 0 loads `cmdData` into the addressed mask register (bit n = 1 masks input n). Opcode 2 loads `cmdData[7:3]` as the addressed unit's vector base.
- R10: External line 2 has no effect.
- R11: An acknowledge while `intOut` is 0 returns {master base, 3'd7} and changes no register.
- R12: `vectorValid` is high exactly in the cycle after `ackStrobe`, and the acknowledged request is cleared from the request register. A new rising edge in the acknowledge cycle keeps that request latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 16 | Request lines; 0–7 master, 8–15 slave |
| intOut | output | 1 | Interrupt to processor |
| ackStrobe | input | 1 | One-cycle acknowledge |
| vectorOut | output | 8 | Vector of the acknowledged request |
| vectorValid | output | 1 | Vector valid, one cycle after acknowledge |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 mask, 1 end of interrupt, 2 vector base, 3 mode |
| cmdTarget | input | 1 | 0 master, 1 slave |
| cmdData | input | 8 | Command operand |

## Verification
Two events can land on the same request bit in the same cycle: an acknowledge that clears the bit, and a fresh rising edge on that line. The bench provokes this by raising the line in the acknowledge cycle. It judges the result by checking that the vector is correct and that `intOut` returns as soon as the in-service bit is ended. A second collision arises when a chained end of interrupt is issued while the slave still holds a pending request. The bench detects a wrongly cleared master bit by switching to normal nesting and checking that `intOut` stays low.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int UNIT_LINES = 8;
  localparam int NUM_UNITS  = 2;
  localparam int IDX_W      = $clog2(UNIT_LINES);
  localparam int VEC_W      = 8;
  localparam int BASE_W     = VEC_W - IDX_W;
  localparam int ALL_LINES  = UNIT_LINES * NUM_UNITS;

  typedef enum logic [1:0] {
    OP_MASK = 2'd0,
    OP_EOI  = 2'd1,
    OP_BASE = 2'd2,
    OP_MODE = 2'd3
  } cmdOp_e;

  typedef struct packed {
    logic [UNIT_LINES-1:0] setIsr;
    logic [UNIT_LINES-1:0] clrIsr;
    logic [UNIT_LINES-1:0] clrIrr;
    logic                  loadMask;
    logic                  loadBase;
  } unitStrobe_t;

  typedef struct packed {
    unitStrobe_t [NUM_UNITS-1:0] unit;
    logic [UNIT_LINES-1:0]       maskVal;
    logic [BASE_W-1:0]           baseVal;
    logic                        loadMode;
    logic                        modeVal;
    logic                        loadVec;
    logic [VEC_W-1:0]            vecVal;
  } strobe_t;

  function automatic logic [UNIT_LINES-1:0] lowestBit(input logic [UNIT_LINES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IDX_W-1:0] firstIndex(input logic [UNIT_LINES-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = UNIT_LINES - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  // Bits strictly above (in priority) the highest in-service bit.
  function automatic logic [UNIT_LINES-1:0] allowMask(input logic [UNIT_LINES-1:0] isr);
    return (isr == '0) ? '1 : (lowestBit(isr) - 1'b1);
  endfunction
endpackage

// File: rtl/pic_cascade_dp.sv
module pic_cascade_dp
  import pic_cascade_pkg::*;
#(
  parameter int                 CASCADE_PORT    = 2,
  parameter logic [BASE_W-1:0]  MASTER_BASE_RST = 5'h01,
  parameter logic [BASE_W-1:0]  SLAVE_BASE_RST  = 5'h0E
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [ALL_LINES-1:0]                  irqLines,
  input  strobe_t                               st,
  output logic [NUM_UNITS-1:0][UNIT_LINES-1:0]  irrQ,
  output logic [NUM_UNITS-1:0][UNIT_LINES-1:0]  imrQ,
  output logic [NUM_UNITS-1:0][UNIT_LINES-1:0]  isrQ,
  output logic [NUM_UNITS-1:0][BASE_W-1:0]      baseQ,
  output logic                                  specialQ,
  output logic [VEC_W-1:0]                      vectorOut,
  output logic                                  vectorValid
);
  localparam logic [UNIT_LINES-1:0] CASC_BIT = UNIT_LINES'(1) << CASCADE_PORT;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    localparam logic [UNIT_LINES-1:0] LINE_KEEP = (u == 0) ? ~CASC_BIT : '1;
    localparam logic [BASE_W-1:0]     BASE_RST  = (u == 0) ? MASTER_BASE_RST : SLAVE_BASE_RST;

    logic [UNIT_LINES-1:0] lines, prevR, irrR, imrR, isrR;
    logic [BASE_W-1:0]     baseR;

    assign lines = irqLines[u*UNIT_LINES +: UNIT_LINES] & LINE_KEEP;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevR <= '0;
        irrR  <= '0;
        imrR  <= '1;
        isrR  <= '0;
        baseR <= BASE_RST;
      end else begin
        prevR <= lines;
        irrR  <= (irrR & ~st.unit[u].clrIrr) | (lines & ~prevR);
        isrR  <= (isrR & ~st.unit[u].clrIsr) | st.unit[u].setIsr;
        if (st.unit[u].loadMask) imrR  <= st.maskVal;
        if (st.unit[u].loadBase) baseR <= st.baseVal;
      end
    end

    assign irrQ[u]  = irrR;
    assign imrQ[u]  = imrR;
    assign isrQ[u]  = isrR;
    assign baseQ[u] = baseR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specialQ    <= 1'b0;
      vectorOut   <= '0;
      vectorValid <= 1'b0;
    end else begin
      vectorValid <= st.loadVec;
      if (st.loadVec)  vectorOut <= st.vecVal;
      if (st.loadMode) specialQ  <= st.modeVal;
    end
  end
endmodule

// File: rtl/pic_cascade_ctrl.sv
module pic_cascade_ctrl
  import pic_cascade_pkg::*;
#(
  parameter int CASCADE_PORT = 2
) (
  input  logic [NUM_UNITS-1:0][UNIT_LINES-1:0]  irrQ,
  input  logic [NUM_UNITS-1:0][UNIT_LINES-1:0]  imrQ,
  input  logic [NUM_UNITS-1:0][UNIT_LINES-1:0]  isrQ,
  input  logic [NUM_UNITS-1:0][BASE_W-1:0]      baseQ,
  input  logic                                  specialQ,
  input  logic                                  ackStrobe,
  input  logic                                  cmdValid,
  input  logic [1:0]                            cmdOp,
  input  logic                                  cmdTarget,
  input  logic [7:0]                            cmdData,
  output logic                                  intOut,
  output strobe_t                               st
);
  localparam logic [UNIT_LINES-1:0] CASC_BIT = UNIT_LINES'(1) << CASCADE_PORT;
  localparam logic [IDX_W-1:0]      LOW_IDX  = IDX_W'(UNIT_LINES - 1);

  logic [UNIT_LINES-1:0] slaveCand, masterIn, masterAllow, masterCand;
  logic [UNIT_LINES-1:0] slaveRemain;
  logic                  slaveInt;
  logic [IDX_W-1:0]      masterPick, slavePick;

  // Priority resolution for both units.
  always_comb begin
    slaveCand = irrQ[1] & ~imrQ[1] & allowMask(isrQ[1]);
    slaveInt  = |slaveCand;
    masterIn  = (irrQ[0] & ~CASC_BIT) | (slaveInt ? CASC_BIT : '0);
    masterAllow = allowMask(isrQ[0]);
    if (specialQ && (lowestBit(isrQ[0]) == CASC_BIT)) masterAllow = masterAllow | CASC_BIT;
    masterCand = masterIn & ~imrQ[0] & masterAllow;
    intOut     = |masterCand;
    masterPick = firstIndex(masterCand);
    slavePick  = firstIndex(slaveCand);
    slaveRemain = (isrQ[1] & ~lowestBit(isrQ[1])) | (irrQ[1] & ~imrQ[1]);
  end

  // Strobe generation for acknowledge and commands.
  always_comb begin
    st = '0;
    if (ackStrobe) begin
      st.loadVec = 1'b1;
      if (!intOut) begin
        st.vecVal = {baseQ[0], LOW_IDX};
      end else if (masterCand[CASCADE_PORT] && masterPick == IDX_W'(CASCADE_PORT)) begin
        st.unit[0].setIsr = CASC_BIT;
        st.unit[1].setIsr = lowestBit(slaveCand);
        st.unit[1].clrIrr = lowestBit(slaveCand);
        st.vecVal = {baseQ[1], slavePick};
      end else begin
        st.unit[0].setIsr = lowestBit(masterCand);
        st.unit[0].clrIrr = lowestBit(masterCand);
        st.vecVal = {baseQ[0], masterPick};
      end
    end
    if (cmdValid) begin
      unique case (cmdOp_e'(cmdOp))
        OP_MASK: begin
          st.unit[cmdTarget].loadMask = 1'b1;
          st.maskVal = cmdData;
        end
        OP_EOI: begin
          st.unit[cmdTarget].clrIsr = lowestBit(isrQ[cmdTarget]);
          if (cmdTarget && cmdData[0] && (slaveRemain == '0))
            st.unit[0].clrIsr = lowestBit(isrQ[0]);
        end
        OP_BASE: begin
          st.unit[cmdTarget].loadBase = 1'b1;
          st.baseVal = cmdData[VEC_W-1:IDX_W];
        end
        OP_MODE: begin
          st.loadMode = 1'b1;
          st.modeVal  = cmdData[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_cascade_pkg::*;
#(
  parameter int                CASCADE_PORT    = 2,
  parameter logic [BASE_W-1:0] MASTER_BASE_RST = 5'h01,
  parameter logic [BASE_W-1:0] SLAVE_BASE_RST  = 5'h0E
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ALL_LINES-1:0] irqLines,
  output logic                 intOut,
  input  logic                 ackStrobe,
  output logic [VEC_W-1:0]     vectorOut,
  output logic                 vectorValid,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic                 cmdTarget,
  input  logic [7:0]           cmdData
);
  strobe_t                              st;
  logic [NUM_UNITS-1:0][UNIT_LINES-1:0] irrQ, imrQ, isrQ;
  logic [NUM_UNITS-1:0][BASE_W-1:0]     baseQ;
  logic                                 specialQ;

  pic_cascade_dp #(
    .CASCADE_PORT(CASCADE_PORT),
    .MASTER_BASE_RST(MASTER_BASE_RST),
    .SLAVE_BASE_RST(SLAVE_BASE_RST)
  ) uDp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .st(st),
    .irrQ(irrQ), .imrQ(imrQ), .isrQ(isrQ), .baseQ(baseQ),
    .specialQ(specialQ), .vectorOut(vectorOut), .vectorValid(vectorValid)
  );

  pic_cascade_ctrl #(.CASCADE_PORT(CASCADE_PORT)) uCtrl (
    .irrQ(irrQ), .imrQ(imrQ), .isrQ(isrQ), .baseQ(baseQ), .specialQ(specialQ),
    .ackStrobe(ackStrobe), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdTarget(cmdTarget), .cmdData(cmdData), .intOut(intOut), .st(st)
  );
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk
  import pic_cascade_pkg::*;
(
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 ackStrobe,
  input logic                                 intOut,
  input logic                                 vectorValid,
  input logic                                 cmdValid,
  input logic [NUM_UNITS-1:0][UNIT_LINES-1:0] imrQ,
  input logic [NUM_UNITS-1:0][UNIT_LINES-1:0] isrQ,
  input logic                                 specialQ
);
  // R2: fully masked master never interrupts
  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (imrQ[0] == '1) |-> !intOut);

  // R3: acknowledge sets at most one in-service bit per unit
  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> ($onehot0(isrQ[0] & ~$past(isrQ[0])) && $onehot0(isrQ[1] & ~$past(isrQ[1]))));

  // R4: in-service bits only fall after a command
  assert_hold_until_eoi_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (((isrQ[0] & $past(isrQ[0])) == $past(isrQ[0])) &&
                   ((isrQ[1] & $past(isrQ[1])) == $past(isrQ[1]))));

  // R5: one end of interrupt clears at most one bit per unit
  assert_eoi_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (($countones($past(isrQ[0]) & ~isrQ[0]) <= 1) &&
                  ($countones($past(isrQ[1]) & ~isrQ[1]) <= 1)));

  // R6: normal nesting keeps slave in-service untouched while cascade in service
  assert_normal_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !cmdValid && !specialQ && isrQ[0][2]) |=> (isrQ[1] == $past(isrQ[1])));

  // R11: acknowledge with no interrupt changes nothing
  assert_spurious_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !intOut && !cmdValid) |=> ($stable(isrQ[0]) && $stable(isrQ[1])));

  // R12: vector valid follows acknowledge by one cycle
  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> vectorValid);
  assert_valid_only_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> !vectorValid);
endmodule

bind pic_cascade pic_cascade_chk uChk (
  .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .intOut(intOut),
  .vectorValid(vectorValid), .cmdValid(cmdValid), .imrQ(imrQ),
  .isrQ(isrQ), .specialQ(specialQ)
);

// File: tb/sim_pic_cascade.sv
module sim_pic_cascade;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqLines = '0;
  logic        intOut, vectorValid;
  logic [7:0]  vectorOut;
  logic        ackStrobe = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic        cmdTarget = 1'b0;
  logic [7:0]  cmdData = '0;
  int checks = 0;
  int fails  = 0;

  localparam logic [1:0] MASK = 2'd0, EOI = 2'd1, BASE = 2'd2, MODE = 2'd3;

  // {line number, expected vector}
  localparam logic [11:0] singleVec [0:6] = '{12'h008, 12'h109, 12'h30B, 12'h70F,
                                              12'h870, 12'hD75, 12'hF77};

  always #4 clk = ~clk;

  pic_cascade u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .intOut(intOut),
    .ackStrobe(ackStrobe), .vectorOut(vectorOut), .vectorValid(vectorValid),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdTarget(cmdTarget), .cmdData(cmdData)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    irqLines[n] = 1'b1;
    tick;
    irqLines[n] = 1'b0;
    tick;
  endtask

  task automatic doCmd(input logic [1:0] op, input logic tgt, input logic [7:0] data);
    cmdValid = 1'b1; cmdOp = op; cmdTarget = tgt; cmdData = data;
    tick;
    cmdValid = 1'b0;
  endtask

  task automatic doAck(input logic [7:0] exp, input string req);
    ackStrobe = 1'b1;
    tick;
    ackStrobe = 1'b0;
    chk({7'd0, vectorValid}, 8'd1, req);
    chk(vectorOut, exp, req);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rstN = 1'b1;
    tick;
    // R1 reset state
    chk({7'd0, intOut}, 8'd0, "R1 intOut");
    chk({7'd0, vectorValid}, 8'd0, "R1 vectorValid");
    // R2 masked line latched but quiet
    pulse(0);
    chk({7'd0, intOut}, 8'd0, "R2 masked line 0");
    doCmd(MASK, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd1, "R2 unmasked latched line 0");
    doAck(8'h08, "R1 R3 master base reset");
    doCmd(EOI, 1'b0, 8'h00);
    doCmd(MASK, 1'b1, 8'h00);

    // R3 table of single requests
    for (int i = 0; i < 7; i++) begin
      int ln;
      ln = int'(singleVec[i][11:8]);
      pulse(ln);
      chk({7'd0, intOut}, 8'd1, "R3 table intOut");
      doAck(singleVec[i][7:0], "R3 table vector");
      if (ln >= 8) doCmd(EOI, 1'b1, 8'h01);
      else         doCmd(EOI, 1'b0, 8'h00);
      chk({7'd0, intOut}, 8'd0, "R8 R5 table cleared");
    end

    // R3 mixed priority order 1, 9, 12, 5
    irqLines = 16'h1222;
    tick;
    irqLines = '0;
    tick;
    doAck(8'h09, "R3 order first");
    doCmd(EOI, 1'b0, 8'h00);
    doAck(8'h71, "R3 order second");
    doCmd(EOI, 1'b1, 8'h00);
    doCmd(EOI, 1'b0, 8'h00);
    doAck(8'h74, "R3 order third");
    doCmd(EOI, 1'b1, 8'h00);
    doCmd(EOI, 1'b0, 8'h00);
    doAck(8'h0D, "R3 order fourth");
    doCmd(EOI, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd0, "R3 order drained");

    // R4 R5 nesting within master
    pulse(5);
    doAck(8'h0D, "R4 take 5");
    pulse(6);
    chk({7'd0, intOut}, 8'd0, "R4 lower blocked");
    pulse(5);
    chk({7'd0, intOut}, 8'd0, "R4 same blocked");
    pulse(0);
    chk({7'd0, intOut}, 8'd1, "R4 higher passes");
    doAck(8'h08, "R4 take 0");
    doCmd(EOI, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd0, "R5 cleared highest only");
    doCmd(EOI, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd1, "R5 second clears 5");
    doAck(8'h0D, "R4 relatched 5");
    doCmd(EOI, 1'b0, 8'h00);
    doAck(8'h0E, "R4 pending 6");
    doCmd(EOI, 1'b0, 8'h00);

    // R6 normal nesting blocks slave
    pulse(12);
    doAck(8'h74, "R6 take 12");
    pulse(9);
    chk({7'd0, intOut}, 8'd0, "R6 higher slave blocked");
    // R7 special nesting lets it through
    doCmd(MODE, 1'b0, 8'h01);
    chk({7'd0, intOut}, 8'd1, "R7 special forwards 9");
    doAck(8'h71, "R7 take 9");
    pulse(14);
    chk({7'd0, intOut}, 8'd0, "R7 lower slave blocked");
    doCmd(EOI, 1'b1, 8'h00);
    doCmd(EOI, 1'b1, 8'h00);
    doCmd(EOI, 1'b0, 8'h00);
    doAck(8'h76, "R7 pending 14");
    doCmd(EOI, 1'b1, 8'h00);
    doCmd(EOI, 1'b0, 8'h00);

    // R8 chained end of interrupt
    irqLines = 16'h1200;
    tick;
    irqLines = '0;
    tick;
    doAck(8'h71, "R8 take 9");
    doCmd(EOI, 1'b1, 8'h01);
    doCmd(MODE, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd0, "R8 master kept while 12 pending");
    doCmd(MODE, 1'b0, 8'h01);
    doAck(8'h74, "R8 take 12");
    doCmd(EOI, 1'b1, 8'h01);
    doCmd(MODE, 1'b0, 8'h00);
    pulse(3);
    chk({7'd0, intOut}, 8'd1, "R8 master cleared when slave empty");
    doAck(8'h0B, "R8 take 3");
    doCmd(EOI, 1'b0, 8'h00);

    // R10 line 2 ignored, R11 spurious acknowledge
    pulse(2);
    chk({7'd0, intOut}, 8'd0, "R10 line 2 ignored");
    doAck(8'h0F, "R11 spurious vector");
    chk({7'd0, intOut}, 8'd0, "R11 no state change");
    pulse(7);
    doAck(8'h0F, "R11 line 7 not blocked");
    doCmd(EOI, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd0, "R11 drained");

    // R9 mask write and base write
    doCmd(MASK, 1'b0, 8'h08);
    pulse(3);
    chk({7'd0, intOut}, 8'd0, "R9 mask bit 3");
    doCmd(MASK, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd1, "R9 unmask bit 3");
    doAck(8'h0B, "R9 take 3");
    doCmd(EOI, 1'b0, 8'h00);
    doCmd(BASE, 1'b0, 8'h20);
    doCmd(BASE, 1'b1, 8'h48);
    pulse(4);
    doAck(8'h24, "R9 master base");
    doCmd(EOI, 1'b0, 8'h00);
    pulse(10);
    doAck(8'h4A, "R9 slave base");
    doCmd(EOI, 1'b1, 8'h01);
    doCmd(BASE, 1'b0, 8'h08);

    // R12 new edge in the acknowledge cycle
    pulse(6);
    irqLines[6] = 1'b1;
    ackStrobe = 1'b1;
    tick;
    ackStrobe = 1'b0;
    irqLines[6] = 1'b0;
    chk(vectorOut, 8'h0E, "R12 vector");
    chk({7'd0, intOut}, 8'd0, "R12 in service");
    tick;
    chk({7'd0, vectorValid}, 8'd0, "R12 valid one cycle");
    doCmd(EOI, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd1, "R12 relatched request");
    doAck(8'h0E, "R12 second take");
    doCmd(EOI, 1'b0, 8'h00);
    chk({7'd0, intOut}, 8'd0, "R12 acked request cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule